// File: doc/BRIEF.md
# Control State Sequencer

This block generates the control states of a memory-management controller. The state has two parts. The major part is a small binary counter, decoded into one-hot lines. The minor part is a twisted-ring (Johnson) register. It walks an eight-position sequence in which exactly one bit changes at every step.

Each major/minor pair is decoded into its own state-active line. Every such line comes out in an active-low form and in an active-high form. Surrounding control logic decides when each part advances. That logic drives the major-step, minor-step and minor-clear strobes and uses the state lines to gate its own actions.

The major counter has two named transitions: HOLD and STEP, where STEP wraps from the last state back to 0. The minor register has three named transitions: HOLD, STEP and CLEAR. Its named states are the positions M0 to M7, which carry the codes 0, 1, 3, 7, 15, 14, 12 and 8. With the default parameters there are 4 major states and 8 minor states, giving 32 combined state lines.

Top module: `ctl_state_seq`

## Requirements
- R1: While `rst_n` is low, and after it rises, the major state is 0 and the minor state is position M0 with code 0. Only combined line 0 is active.
- R2: A clock edge with `maj_step` high raises the major state by one. A clock edge with `maj_step` low leaves the major state unchanged.
- R3: A major step taken from the last major state (3 by default) returns the major state to 0.
- R4: `major_oh` has exactly one bit set, and that bit's index equals the major state.
- R5: Each minor step moves to the next position in the order 0, 1, 3, 7, 15, 14, 12, 8 (positions M0 to M7). `minor_code` shows the code of the current position. `minor_dec` has exactly one bit set, at the index of the current position.
- R6: A minor step taken from position M7 (code 8) returns the minor state to M0 (code 0).
- R7: `min_clr` forces the minor state to M0 on the next edge and overrides `min_step`. It does not change the major state: a `maj_step` on the same edge still takes effect.
- R8: A clock edge with both `min_step` and `min_clr` low leaves the minor state unchanged.
- R9: `st_act` has exactly one bit set. Its index is major × 8 + minor position, for every pair.
- R10: `st_act_n` is the bitwise complement of `st_act`, so exactly one of its bits is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| maj_step | input | 1 | Advance the major state |
| min_step | input | 1 | Advance the minor state |
| min_clr | input | 1 | Return the minor state to M0 |
| major_oh | output | 4 | One-hot major state lines |
| minor_code | output | 4 | Current twisted-ring minor code |
| minor_dec | output | 8 | One-hot minor position lines |
| st_act | output | 32 | Combined state lines, active high |
| st_act_n | output | 32 | Combined state lines, active low |

## Verification
The bench builds the block with its default parameters: a 2-bit major counter and a 4-bit ring, which gives 4 major states, 8 minor positions and 32 combined lines. At this size the bench walks every one of the 32 major/minor pairs. It also reaches both wrap points: minor M7 back to M0, and major 3 back to 0. The bench exercises a clear that coincides with a minor step, and a clear that coincides with a major step.

// File: rtl/ctl_state_pkg.sv
package ctl_state_pkg;

    // Minor-state transition chosen on each clock edge
    typedef enum logic [1:0] {
        MIN_HOLD  = 2'd0,
        MIN_STEP  = 2'd1,
        MIN_CLEAR = 2'd2
    } min_act_e;

    // Major-state transition chosen on each clock edge
    typedef enum logic {
        MAJ_HOLD = 1'b0,
        MAJ_STEP = 1'b1
    } maj_act_e;

    // Code held by a w-bit twisted ring at position p (0 .. 2w-1).
    // The ring fills with ones from the bottom, then empties from the bottom.
    function automatic logic [31:0] ring_code(int w, int p);
        logic [31:0] full;
        logic [31:0] low;
        full = (32'd1 << w) - 32'd1;
        if (p <= w) begin
            ring_code = (32'd1 << p) - 32'd1;
        end else begin
            low       = (32'd1 << (p - w)) - 32'd1;
            ring_code = full & ~low;
        end
    endfunction

endpackage

// File: rtl/ctl_major_ctr.sv
module ctl_major_ctr
    import ctl_state_pkg::*;
#(
    parameter int MAJ_W = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    step,
    output logic [(1<<MAJ_W)-1:0]   oh
);
    localparam int NUM_MAJ = 1 << MAJ_W;

    logic [MAJ_W-1:0] cnt_q;
    maj_act_e         act;

    assign act = step ? MAJ_STEP : MAJ_HOLD;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            unique case (act)
                MAJ_STEP: cnt_q <= cnt_q + 1'b1;
                MAJ_HOLD: cnt_q <= cnt_q;
                default:  cnt_q <= cnt_q;
            endcase
        end
    end

    for (genvar i = 0; i < NUM_MAJ; i++) begin : g_oh
        assign oh[i] = (cnt_q == MAJ_W'(i));
    end

    // R2: stepping raises the count by one
    assert_major_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (act == MAJ_STEP && cnt_q != MAJ_W'(NUM_MAJ-1)) |=> (cnt_q == $past(cnt_q) + 1'b1));
    // R2: holding keeps the count
    assert_major_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (act == MAJ_HOLD) |=> $stable(cnt_q));
    // R3: the last state wraps to 0
    assert_major_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (act == MAJ_STEP && cnt_q == MAJ_W'(NUM_MAJ-1)) |=> (cnt_q == '0));
    // R4: the decode lines are one-hot
    assert_major_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(oh) == 1);

endmodule

// File: rtl/ctl_minor_ring.sv
module ctl_minor_ring
    import ctl_state_pkg::*;
#(
    parameter int RING_W = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  step,
    input  logic                  clr,
    output logic [RING_W-1:0]     code,
    output logic [2*RING_W-1:0]   dec
);
    localparam int NUM_POS = 2 * RING_W;

    logic [RING_W-1:0] code_q;
    logic [RING_W-1:0] code_nxt;
    min_act_e          act;

    // CLEAR takes priority over STEP
    always_comb begin
        if (clr)       act = MIN_CLEAR;
        else if (step) act = MIN_STEP;
        else           act = MIN_HOLD;
    end

    assign code_nxt = {code_q[RING_W-2:0], ~code_q[RING_W-1]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '0;
        end else begin
            unique case (act)
                MIN_CLEAR: code_q <= '0;
                MIN_STEP:  code_q <= code_nxt;
                MIN_HOLD:  code_q <= code_q;
                default:   code_q <= code_q;
            endcase
        end
    end

    assign code = code_q;

    for (genvar p = 0; p < NUM_POS; p++) begin : g_dec
        localparam logic [31:0] PCODE = ring_code(RING_W, p);
        assign dec[p] = (code_q == PCODE[RING_W-1:0]);
    end

    // R7: clear returns the ring to position 0
    assert_minor_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (code_q == '0));
    // R8: no strobe keeps the ring
    assert_minor_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !step) |=> $stable(code_q));
    // R5: a step moves exactly one bit
    assert_minor_onebit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clr) |=> ($countones(code_q ^ $past(code_q)) == 1));
    // R5: exactly one position line is active
    assert_minor_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(dec) == 1);
    // R6: the last position steps back to position 0
    assert_minor_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clr && dec[NUM_POS-1]) |=> dec[0]);

endmodule

// File: rtl/ctl_pair_decode.sv
module ctl_pair_decode #(
    parameter int NUM_MAJ = 4,
    parameter int NUM_POS = 8
) (
    input  logic [NUM_MAJ-1:0]          maj_oh,
    input  logic [NUM_POS-1:0]          min_dec,
    output logic [NUM_MAJ*NUM_POS-1:0]  act_n,
    output logic [NUM_MAJ*NUM_POS-1:0]  act
);
    for (genvar i = 0; i < NUM_MAJ; i++) begin : g_maj
        for (genvar j = 0; j < NUM_POS; j++) begin : g_min
            // active-low gate first, active-high copy through an inverter
            assign act_n[i*NUM_POS + j] = ~(maj_oh[i] & min_dec[j]);
            assign act[i*NUM_POS + j]   = ~act_n[i*NUM_POS + j];
        end
    end
endmodule

// File: rtl/ctl_state_seq.sv
module ctl_state_seq #(
    parameter int MAJ_W  = 2,
    parameter int RING_W = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            maj_step,
    input  logic                            min_step,
    input  logic                            min_clr,
    output logic [(1<<MAJ_W)-1:0]           major_oh,
    output logic [RING_W-1:0]               minor_code,
    output logic [2*RING_W-1:0]             minor_dec,
    output logic [(2*RING_W<<MAJ_W)-1:0]    st_act,
    output logic [(2*RING_W<<MAJ_W)-1:0]    st_act_n
);
    localparam int NUM_MAJ = 1 << MAJ_W;
    localparam int NUM_POS = 2 * RING_W;

    ctl_major_ctr #(.MAJ_W(MAJ_W)) i_major (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (maj_step),
        .oh    (major_oh)
    );

    ctl_minor_ring #(.RING_W(RING_W)) i_minor (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (min_step),
        .clr   (min_clr),
        .code  (minor_code),
        .dec   (minor_dec)
    );

    ctl_pair_decode #(.NUM_MAJ(NUM_MAJ), .NUM_POS(NUM_POS)) i_pairs (
        .maj_oh  (major_oh),
        .min_dec (minor_dec),
        .act_n   (st_act_n),
        .act     (st_act)
    );

    // R9: exactly one combined line is active
    assert_one_state_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(st_act) == 1);
    // R10: exactly one active-low line is low
    assert_one_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~st_act_n) == 1);
    // R7: the minor clear leaves the major state alone
    assert_clr_keeps_major_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (min_clr && !maj_step) |=> $stable(major_oh));

endmodule

// File: tb/test_ctl_state_seq.sv
module test_ctl_state_seq;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        maj_step = 1'b0;
    logic        min_step = 1'b0;
    logic        min_clr = 1'b0;
    logic [3:0]  major_oh;
    logic [3:0]  minor_code;
    logic [7:0]  minor_dec;
    logic [31:0] st_act;
    logic [31:0] st_act_n;

    int n_run = 0;
    int n_fail = 0;
    int exp_maj = 0;
    int exp_pos = 0;
    logic [3:0] codes [8] = '{4'd0, 4'd1, 4'd3, 4'd7, 4'd15, 4'd14, 4'd12, 4'd8};

    always #(CLK_P/2) clk = ~clk;

    ctl_state_seq i_ctl_state_seq (
        .clk(clk), .rst_n(rst_n), .maj_step(maj_step), .min_step(min_step),
        .min_clr(min_clr), .major_oh(major_oh), .minor_code(minor_code),
        .minor_dec(minor_dec), .st_act(st_act), .st_act_n(st_act_n)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // compare every output against the model
    task automatic chk_all(input string tag);
        logic [31:0] exp_st;
        exp_st = 32'd1 << (exp_maj*8 + exp_pos);
        chk(major_oh == 4'(1 << exp_maj), {tag, " R4 major_oh"}, 32'(major_oh), 32'(1 << exp_maj));
        chk(minor_code == codes[exp_pos], {tag, " R5 minor_code"}, 32'(minor_code), 32'(codes[exp_pos]));
        chk(minor_dec == 8'(1 << exp_pos), {tag, " R5 minor_dec"}, 32'(minor_dec), 32'(1 << exp_pos));
        chk(st_act == exp_st, {tag, " R9 st_act"}, st_act, exp_st);
        chk(st_act_n == ~exp_st, {tag, " R10 st_act_n"}, st_act_n, ~exp_st);
    endtask

    // drive one edge's worth of strobes, update the model, check after the edge
    task automatic cycle(input bit ms, input bit ns, input bit nc, input string tag);
        @(negedge clk);
        maj_step = ms; min_step = ns; min_clr = nc;
        @(posedge clk);
        if (ms) exp_maj = (exp_maj + 1) % 4;
        if (nc) exp_pos = 0;
        else if (ns) exp_pos = (exp_pos + 1) % 8;
        #1;
        chk_all(tag);
        @(negedge clk);
        maj_step = 1'b0; min_step = 1'b0; min_clr = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        exp_maj = 0; exp_pos = 0;
        #(CLK_P*2 + 1);
        chk_all("R1 in reset");
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk_all("R1 after reset");
    endtask

    // R5 R6 R9: every pair in turn, with both wraps
    task automatic t_full_walk();
        for (int m = 0; m < 4; m++) begin
            for (int p = 0; p < 8; p++) cycle(1'b0, 1'b1, 1'b0, "R5 R6 minor walk");
            cycle(1'b1, 1'b0, 1'b0, "R2 R3 major step");
        end
    endtask

    task automatic t_hold();
        cycle(1'b0, 1'b1, 1'b0, "R5 setup");
        cycle(1'b0, 1'b1, 1'b0, "R5 setup");
        cycle(1'b1, 1'b0, 1'b0, "R2 setup");
        for (int k = 0; k < 3; k++) cycle(1'b0, 1'b0, 1'b0, "R8 R2 idle hold");
    endtask

    task automatic t_clear();
        cycle(1'b0, 1'b1, 1'b1, "R7 clear over step");
        cycle(1'b0, 1'b1, 1'b0, "R5 step");
        cycle(1'b0, 1'b1, 1'b0, "R5 step");
        cycle(1'b0, 1'b0, 1'b1, "R7 clear keeps major");
        cycle(1'b0, 1'b1, 1'b0, "R5 step");
        cycle(1'b1, 1'b1, 1'b1, "R7 clear with major step");
    endtask

    task automatic t_both_step();
        cycle(1'b1, 1'b1, 1'b0, "R2 R5 both step");
        cycle(1'b1, 1'b1, 1'b0, "R3 R5 both step");
    endtask

    initial begin
        #(CLK_P*100000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_full_walk();
        t_hold();
        t_clear();
        t_both_step();
        t_reset();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule